// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by N = P*B + A and emits one single-cycle comparison pulse per N input cycles for a phase detector. It carries a logic model of a dual-modulus prescaler that divides by P or P+1. A swallow counter loaded with A and a main counter loaded with B steer the prescaler through a modulus-control signal. At the start of each output period the prescaler runs at P+1 for A of its output ticks. It then runs at P for the remaining B-A ticks, so A extra input cycles are swallowed per period. A mode input selects the small prescaler ratio of 64/65 or the large one of 128/129.

Settings are presented on parallel inputs and captured on a one-cycle load strobe. A captured setting is held as pending and only becomes active at the next period boundary. The counters reload on that same edge, so no period runs with a mix of old and new values. A setting that breaks the counter rules is refused. The block raises an error flag and keeps whatever was held before. After reset the divider runs with A = 0, B = 3 and the small ratio, which gives N = 192.

Top module: `swallow_divider`

## Requirements
- R1: The interval between successive `divPulse` assertions is P*B + A input cycles, where P = 64 when the active mode bit is 1 and P = 128 when it is 0.
- R2: Within each period, `modCtrl` is high for exactly A*(P+1) input cycles, starting in the cycle where `divPulse` is high. When A = 0 it stays low for the whole period.
- R3: `divPulse` is high for exactly one input cycle per period.
- R4: A setting accepted by `loadStb` in the middle of a period does not alter that period. The period that follows uses the new A, B and mode in full.
- R5: A load with B < 3 or B < A sets `cfgErr` to 1 in the next cycle and leaves the held and active settings unchanged. A load with B >= 3 and B >= A clears `cfgErr`.
- R6: When several loads arrive within one period, the last acceptable one is the one applied at the next boundary. A later refused load does not discard it.
- R7: During and after reset, `divPulse`, `modCtrl` and `cfgErr` are 0. The divider then runs with A = 0, B = 3 and mode 1, which gives periods of 192 cycles.
- R8: With A = B, every prescaler tick of the period is P+1 cycles long, so N = B*(P+1) and `modCtrl` is high for the entire period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rstN | input | 1 | Active-low synchronous reset |
| swallowIn | input | 7 | Swallow count A, captured on `loadStb` |
| mainIn | input | 11 | Main count B, captured on `loadStb` |
| modeSel | input | 1 | Prescaler pair: 1 selects 64/65, 0 selects 128/129 |
| loadStb | input | 1 | One-cycle strobe that captures the three setting inputs |
| divPulse | output | 1 | One-cycle pulse per output period |
| modCtrl | output | 1 | Modulus control: 1 while the prescaler divides by P+1 |
| cfgErr | output | 1 | Set by a refused load, cleared by an accepted one |

## Verification
The hardest case to reach from the ports is the hand-over between settings. The bench has to show that a load landing mid-period leaves that period alone, and that the very next period already carries the new ratio with no cycle of blending. The stimulus lines each load up with the cycle just after a pulse, so the boundary that follows is known. It then measures two whole periods: the old one from the pulse, and the new one to the next pulse. The same scheme is used to stack two loads in one period, and to follow an accepted load with a refused one. It also drives the extremes A = 0 and A = B, up to A = B = 127.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic reload;   // period boundary: counters take the next settings
    logic swStep;   // swallow counter steps down
    logic mnStep;   // main counter steps down
    logic modHi;    // prescaler runs at P+1
    logic smallP;   // active pair is the small one
  } dvCmd_t;

  // datapath -> control status
  typedef struct packed {
    logic presTick; // prescaler output edge this cycle
    logic swLeft;   // swallow counter not yet exhausted
    logic mainLast; // main counter on its final tick
  } dvSts_t;

endpackage

// File: rtl/swdiv_ctrl.sv
module swdiv_ctrl
  import swdiv_pkg::*;
#(
  parameter int SW_W     = 7,
  parameter int MN_W     = 11,
  parameter int MIN_MAIN = 3,
  parameter int DEF_SW   = 0,
  parameter int DEF_MN   = 3,
  parameter bit DEF_MODE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadStb,
  input  logic [SW_W-1:0] swIn,
  input  logic [MN_W-1:0] mnIn,
  input  logic            modeIn,
  input  dvSts_t          sts,
  output dvCmd_t          cmd,
  output logic [SW_W-1:0] nextSw,
  output logic [MN_W-1:0] nextMn,
  output logic            cfgErr
);

  localparam int PAD = MN_W - SW_W;

  logic [SW_W-1:0] pendSw, actSw;
  logic [MN_W-1:0] pendMn, actMn;
  logic            pendMode, actMode, pendValid;
  logic            badCfg, nextMode;

  assign badCfg = (mnIn < MN_W'(MIN_MAIN)) || (mnIn < {{PAD{1'b0}}, swIn});

  assign nextSw   = pendValid ? pendSw   : actSw;
  assign nextMn   = pendValid ? pendMn   : actMn;
  assign nextMode = pendValid ? pendMode : actMode;

  always_comb begin
    cmd.reload = sts.presTick && sts.mainLast;
    cmd.swStep = sts.presTick && sts.swLeft;
    cmd.mnStep = sts.presTick;
    cmd.modHi  = sts.swLeft;
    cmd.smallP = actMode;
  end

  // pending settings: written by accepted loads only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSw    <= SW_W'(DEF_SW);
      pendMn    <= MN_W'(DEF_MN);
      pendMode  <= DEF_MODE;
      pendValid <= 1'b0;
      cfgErr    <= 1'b0;
    end else begin
      if (cmd.reload) pendValid <= 1'b0;
      if (loadStb) begin
        if (badCfg) begin
          cfgErr <= 1'b1;
        end else begin
          cfgErr    <= 1'b0;
          pendSw    <= swIn;
          pendMn    <= mnIn;
          pendMode  <= modeIn;
          pendValid <= 1'b1;
        end
      end
    end
  end

  // active settings: change only on the boundary edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actSw   <= SW_W'(DEF_SW);
      actMn   <= MN_W'(DEF_MN);
      actMode <= DEF_MODE;
    end else if (cmd.reload) begin
      actSw   <= nextSw;
      actMn   <= nextMn;
      actMode <= nextMode;
    end
  end

  AST_ACTIVE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.reload |=> ($stable(actSw) && $stable(actMn) && $stable(actMode))); // R4

  AST_REFUSED_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && badCfg) |=> ($stable(pendSw) && $stable(pendMn) && $stable(pendMode))); // R5

endmodule

// File: rtl/swdiv_datapath.sv
module swdiv_datapath
  import swdiv_pkg::*;
#(
  parameter int SW_W   = 7,
  parameter int MN_W   = 11,
  parameter int PRE_LO = 64,
  parameter int DEF_SW = 0,
  parameter int DEF_MN = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  dvCmd_t          cmd,
  input  logic [SW_W-1:0] nextSw,
  input  logic [MN_W-1:0] nextMn,
  output dvSts_t          sts,
  output logic            divPulse
);

  localparam int PRE_HI = 2 * PRE_LO;
  localparam int PRES_W = $clog2(PRE_HI + 2);
  localparam int PAD    = MN_W - SW_W;

  logic [PRES_W-1:0] presCnt, pBase, presLast;
  logic [SW_W-1:0]   swCnt;
  logic [MN_W-1:0]   mnCnt;

  // prescaler model: count P or P+1 input cycles per tick
  assign pBase    = cmd.smallP ? PRES_W'(PRE_LO) : PRES_W'(PRE_HI);
  assign presLast = cmd.modHi ? pBase : pBase - PRES_W'(1);

  always_comb begin
    sts.presTick = (presCnt == presLast);
    sts.swLeft   = (swCnt != '0);
    sts.mainLast = (mnCnt == MN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) presCnt <= '0;
    else if (sts.presTick) presCnt <= '0;
    else presCnt <= presCnt + PRES_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swCnt <= SW_W'(DEF_SW);
      mnCnt <= MN_W'(DEF_MN);
    end else if (cmd.reload) begin
      swCnt <= nextSw;
      mnCnt <= nextMn;
    end else begin
      if (cmd.swStep) swCnt <= swCnt - SW_W'(1);
      if (cmd.mnStep) mnCnt <= mnCnt - MN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) divPulse <= 1'b0;
    else divPulse <= cmd.reload;
  end

  AST_SWALLOW_WITHIN_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    ({{PAD{1'b0}}, swCnt} <= mnCnt)); // R5

  AST_MAIN_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (mnCnt != '0)); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse); // R3

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int SW_W     = 7,
  parameter int MN_W     = 11,
  parameter int PRE_LO   = 64,
  parameter int MIN_MAIN = 3,
  parameter int DEF_SW   = 0,
  parameter int DEF_MN   = 3,
  parameter bit DEF_MODE = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SW_W-1:0] swallowIn,
  input  logic [MN_W-1:0] mainIn,
  input  logic            modeSel,
  input  logic            loadStb,
  output logic            divPulse,
  output logic            modCtrl,
  output logic            cfgErr
);

  dvCmd_t          cmd;
  dvSts_t          sts;
  logic [SW_W-1:0] nextSw;
  logic [MN_W-1:0] nextMn;

  swdiv_ctrl #(
    .SW_W(SW_W), .MN_W(MN_W), .MIN_MAIN(MIN_MAIN),
    .DEF_SW(DEF_SW), .DEF_MN(DEF_MN), .DEF_MODE(DEF_MODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb),
    .swIn(swallowIn), .mnIn(mainIn), .modeIn(modeSel),
    .sts(sts), .cmd(cmd), .nextSw(nextSw), .nextMn(nextMn), .cfgErr(cfgErr)
  );

  swdiv_datapath #(
    .SW_W(SW_W), .MN_W(MN_W), .PRE_LO(PRE_LO),
    .DEF_SW(DEF_SW), .DEF_MN(DEF_MN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .nextSw(nextSw), .nextMn(nextMn), .sts(sts), .divPulse(divPulse)
  );

  assign modCtrl = cmd.modHi;

  AST_MODHI_STARTS_AT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modCtrl) |-> divPulse); // R2

endmodule

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;

  logic        clk = 1'b0;
  logic        rstN;
  logic [6:0]  swallowIn;
  logic [10:0] mainIn;
  logic        modeSel;
  logic        loadStb;
  logic        divPulse, modCtrl, cfgErr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  swallow_divider u0 (
    .clk(clk), .rstN(rstN), .swallowIn(swallowIn), .mainIn(mainIn),
    .modeSel(modeSel), .loadStb(loadStb),
    .divPulse(divPulse), .modCtrl(modCtrl), .cfgErr(cfgErr)
  );

  typedef struct packed {
    int a;
    int b;
    int m;
    int n;
  } vec_t;

  // A, B, mode, expected N = P*B + A  (P = 64 for mode 1, 128 for mode 0)
  localparam vec_t VECS [8] = '{
    '{0,   3,   1, 192},
    '{5,   10,  1, 645},
    '{3,   3,   1, 195},
    '{0,   4,   0, 512},
    '{7,   9,   0, 1159},
    '{12,  12,  0, 1548},
    '{127, 127, 1, 8255},
    '{1,   5,   1, 321}
  };

  function automatic int pOf(int m);
    return (m != 0) ? 64 : 128;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitPulse();
    while (!divPulse) @(negedge clk);
  endtask

  // from current cycle up to (not including) the next pulse cycle
  task automatic runToPulse(output int cyc, output int hi);
    cyc = 0;
    hi  = 0;
    do begin
      hi += int'(modCtrl);
      cyc++;
      @(negedge clk);
    end while (!divPulse);
  endtask

  task automatic doLoad(int a, int b, int m);
    swallowIn = 7'(a);
    mainIn    = 11'(b);
    modeSel   = (m != 0);
    loadStb   = 1'b1;
    @(negedge clk);
    loadStb   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3: watchdog expired, actual no pulse expected pulse");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cyc, hi, prevN;
    rstN = 1'b0; loadStb = 1'b0; swallowIn = '0; mainIn = '0; modeSel = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 divPulse in reset", int'(divPulse), 0);
    chk("R7 modCtrl in reset", int'(modCtrl), 0);
    chk("R7 cfgErr in reset", int'(cfgErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7 cfgErr after reset", int'(cfgErr), 0);
    waitPulse();
    runToPulse(cyc, hi);
    chk("R7 default period", cyc, 192);
    chk("R7 default modCtrl low", hi, 0);
    prevN = 192;

    // table walk: each entry loaded just after a pulse
    foreach (VECS[i]) begin
      doLoad(VECS[i].a, VECS[i].b, VECS[i].m);
      runToPulse(cyc, hi);
      chk("R4 old period kept", cyc + 1, prevN);
      runToPulse(cyc, hi);
      chk("R1 ratio", cyc, VECS[i].n);
      chk("R2 modCtrl high cycles", hi, VECS[i].a * (pOf(VECS[i].m) + 1));
      if (VECS[i].a == VECS[i].b) chk("R8 all at P+1", hi, cyc);
      chk("R3 single pulse per period", cyc, pOf(VECS[i].m) * VECS[i].b + VECS[i].a);
      chk("R5 cfgErr clear after good load", int'(cfgErr), 0);
      prevN = VECS[i].n;
    end

    // refused load: B below 3
    doLoad(0, 2, 1);
    chk("R5 cfgErr set on B<3", int'(cfgErr), 1);
    runToPulse(cyc, hi);
    chk("R5 period unchanged", cyc + 1, 321);
    runToPulse(cyc, hi);
    chk("R5 settings held after B<3", cyc, 321);

    // refused load: B below A
    doLoad(9, 8, 0);
    chk("R5 cfgErr set on B<A", int'(cfgErr), 1);
    runToPulse(cyc, hi);
    runToPulse(cyc, hi);
    chk("R5 settings held after B<A", cyc, 321);

    // accepted load clears flag
    doLoad(2, 4, 1);
    chk("R5 cfgErr cleared", int'(cfgErr), 0);
    runToPulse(cyc, hi);
    runToPulse(cyc, hi);
    chk("R1 ratio after recovery", cyc, 258);

    // two accepted loads in one period: last wins
    swallowIn = 7'd0; mainIn = 11'd5; modeSel = 1'b1; loadStb = 1'b1;
    @(negedge clk);
    swallowIn = 7'd4; mainIn = 11'd6; modeSel = 1'b0;
    @(negedge clk);
    loadStb = 1'b0;
    runToPulse(cyc, hi);
    chk("R4 old period with two loads", cyc + 2, 258);
    runToPulse(cyc, hi);
    chk("R6 last load wins", cyc, 772);
    chk("R6 modCtrl of last load", hi, 4 * 129);

    // accepted then refused in one period: accepted one survives
    swallowIn = 7'd0; mainIn = 11'd3; modeSel = 1'b1; loadStb = 1'b1;
    @(negedge clk);
    swallowIn = 7'd0; mainIn = 11'd1;
    @(negedge clk);
    loadStb = 1'b0;
    chk("R5 cfgErr after late refused load", int'(cfgErr), 1);
    runToPulse(cyc, hi);
    runToPulse(cyc, hi);
    chk("R6 accepted load survives refusal", cyc, 192);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule